// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block moves outgoing frames from memory to a byte stream. Software places a chain of descriptors in memory. Each descriptor is three 32-bit little-endian words at consecutive word addresses: the buffer address at offset 0, the size word at offset 4 and the address of the following descriptor at offset 8. Software loads the first descriptor address and sets the DMA enable. The engine then fetches each descriptor and reads its buffer one 32-bit word at a time. It unpacks the words into bytes and presents them on a valid/ready byte stream, with a last marker on the final byte of every frame.

When a frame has been handed over, the engine writes the size word back with its empty flag set and pulses a sent event. It then follows the next pointer. The walk stops when it fetches a descriptor that is already marked empty. The engine reports that stop as an underrun pulse and drops its own enable. A loopback setting sends the bytes to a second stream port in place of the transmit port. The memory side is a simple master: it holds a request until it is granted, and read data comes back later on a valid strobe.

Top module: `tx_desc_dma`

## Requirements
- R1: After a synchronous reset, `dma_en` and `desc_base` read zero, and no memory request, stream valid or event is active.
- R2: A write to the descriptor base register stores the value with bits [1:0] forced to zero, for example 0x103 reads back as 0x100.
- R3: Writing 1 to the DMA enable while `cfg_tx_en` is low sets `dma_en` but issues no memory request. With `cfg_tx_en` high, the same write starts a walk at the stored base address.
- R4: Each descriptor is fetched with three reads, at its address +0, +4 and +8 in that order. A request holds its address, write flag and data until granted. Only one read is outstanding, and its data is taken on `mem_rvalid`.
- R5: The frame length is bits [10:0] of the size word, and the other bits do not change it. Bytes are sent in address order from a word-aligned buffer, byte 0 taken from bits [7:0] of the first word. Bytes of the last word beyond the length are dropped, and the final byte carries `last`.
- R6: A byte offered on a stream port stays unchanged, with the same `last`, until `ready` accepts it.
- R7: A descriptor with length zero produces no bytes and no buffer reads, but it is still written back and counted as sent.
- R8: After a frame, the engine writes the size word OR 0x8000_0000 to the descriptor address +4. It then pulses `evt_sent` for one cycle and fetches the descriptor at the next pointer.
- R9: A fetched descriptor whose size word has bit 31 set causes a one-cycle `evt_underrun` pulse and clears `dma_en`. It causes no write and no bytes, and the engine goes idle.
- R10: With `cfg_loopback` high when a descriptor is accepted, that frame appears only on the loopback port, and the transmit port stays idle.
- R11: A DMA enable write while a walk is in progress is ignored. The walk runs to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | MAC transmit enable |
| cfg_loopback | input | 1 | Route frames to the loopback port |
| dma_en_wr | input | 1 | Software write strobe for the DMA enable |
| dma_en_wdata | input | 1 | Value written to the DMA enable |
| base_wr | input | 1 | Software write strobe for the first descriptor address |
| base_wdata | input | W | First descriptor address value |
| dma_en | output | 1 | Current DMA enable |
| desc_base | output | W | Stored first descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Request byte address |
| mem_wdata | output | W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Transmit sink ready |
| lb_valid | output | 1 | Loopback byte valid |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final loopback byte |
| lb_ready | input | 1 | Loopback sink ready |
| evt_sent | output | 1 | One-cycle pulse per completed descriptor |
| evt_underrun | output | 1 | One-cycle pulse when the chain end is reached |

## Verification
The main walk is tried on a chain that mixes three cases. The first frame has a 5-byte length with stray bits above bit 10, which separates masking from full-word use and tests trimming of a partial last word. The second has zero length, which separates skipping the buffer from skipping the write-back. The third has an exact 8-byte length, which catches an off-by-one in the word count. Grant stalls and sink back-pressure run together, so a byte or address that is lost or repeated under a stall shows up against the expected sequence. Loopback frames, a chain that begins with an empty descriptor, and an enable write while the transmit enable is off each isolate one control path.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_BREQ,
    ST_BWAIT,
    ST_BSEND,
    ST_WBACK
  } walk_st_t;
endpackage

// File: rtl/tx_byte_unpack.sv
// Holds one memory word and hands its bytes out lowest lane first.
module tx_byte_unpack #(
  parameter int W = 32,
  localparam int LANES = W / 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [W-1:0]  ld_word,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_last,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          busy
);
  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q;
  logic          last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      cnt_q  <= ld_cnt;
      last_q <= ld_last;
    end else if (cnt_q != '0 && out_ready) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = word_q[7:0];
  assign out_last  = last_q && (cnt_q == CW'(1));
  assign busy      = out_valid;
endmodule

// File: rtl/tx_stream_steer.sv
// Sends the byte stream to one of two sinks.
module tx_stream_steer (
  input  logic       sel_lb,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic       lb_valid,
  output logic [7:0] lb_data,
  output logic       lb_last,
  input  logic       lb_ready
);
  assign tx_valid = in_valid && !sel_lb;
  assign lb_valid = in_valid && sel_lb;
  assign tx_data  = in_data;
  assign lb_data  = in_data;
  assign tx_last  = in_last && !sel_lb;
  assign lb_last  = in_last && sel_lb;
  assign in_ready = sel_lb ? lb_ready : tx_ready;
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import tx_dma_pkg::*;
#(
  parameter int W         = 32,
  parameter int LEN_W     = 11,
  parameter int EMPTY_BIT = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_tx_en,
  input  logic         cfg_loopback,
  input  logic         dma_en_wr,
  input  logic         dma_en_wdata,
  input  logic         base_wr,
  input  logic [W-1:0] base_wdata,
  output logic         dma_en,
  output logic [W-1:0] desc_base,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_gnt,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  output logic         tx_valid,
  output logic [7:0]   tx_data,
  output logic         tx_last,
  input  logic         tx_ready,
  output logic         lb_valid,
  output logic [7:0]   lb_data,
  output logic         lb_last,
  input  logic         lb_ready,
  output logic         evt_sent,
  output logic         evt_underrun
);
  localparam int              LANES   = W / 8;
  localparam int              CW      = $clog2(LANES + 1);
  localparam logic [W-1:0]    STEP    = W'(LANES);
  localparam logic [LEN_W-1:0] LANES_L = LEN_W'(LANES);

  walk_st_t         st;
  logic             dma_en_q;
  logic [W-1:0]     base_q, ptr_q, buf_q, size_q, next_q;
  logic [1:0]       idx_q;
  logic [LEN_W-1:0] rem_q;
  logic             lb_sel_q, sent_q, und_q;

  logic             ld;
  logic [CW-1:0]    ld_cnt;
  logic             ld_last;
  logic             up_valid, up_last, up_ready, up_busy;
  logic [7:0]       up_data;

  assign ld      = (st == ST_BWAIT) && mem_rvalid;
  assign ld_cnt  = (rem_q >= LANES_L) ? CW'(LANES) : rem_q[CW-1:0];
  assign ld_last = (rem_q <= LANES_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      dma_en_q <= 1'b0;
      base_q   <= '0;
      ptr_q    <= '0;
      buf_q    <= '0;
      size_q   <= '0;
      next_q   <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      lb_sel_q <= 1'b0;
      sent_q   <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      sent_q <= 1'b0;
      und_q  <= 1'b0;
      if (base_wr) base_q <= {base_wdata[W-1:2], 2'b00};
      unique case (st)
        ST_IDLE: begin
          if (dma_en_wr) begin
            dma_en_q <= dma_en_wdata;
            if (dma_en_wdata && cfg_tx_en) begin
              ptr_q <= base_q;
              idx_q <= '0;
              st    <= ST_DREQ;
            end
          end
        end
        ST_DREQ: if (mem_gnt) st <= ST_DWAIT;
        ST_DWAIT: begin
          if (mem_rvalid) begin
            case (idx_q)
              2'd0:    buf_q  <= mem_rdata;
              2'd1:    size_q <= mem_rdata;
              default: next_q <= mem_rdata;
            endcase
            if (idx_q == 2'd2) begin
              if (size_q[EMPTY_BIT]) begin
                dma_en_q <= 1'b0;
                und_q    <= 1'b1;
                st       <= ST_IDLE;
              end else begin
                rem_q    <= size_q[LEN_W-1:0];
                lb_sel_q <= cfg_loopback;
                st       <= (size_q[LEN_W-1:0] == '0) ? ST_WBACK : ST_BREQ;
              end
            end else begin
              idx_q <= idx_q + 2'd1;
              st    <= ST_DREQ;
            end
          end
        end
        ST_BREQ: if (mem_gnt) st <= ST_BWAIT;
        ST_BWAIT: begin
          if (mem_rvalid) begin
            rem_q <= rem_q - LEN_W'(ld_cnt);
            buf_q <= buf_q + STEP;
            st    <= ST_BSEND;
          end
        end
        ST_BSEND: if (!up_busy) st <= (rem_q == '0) ? ST_WBACK : ST_BREQ;
        ST_WBACK: begin
          if (mem_gnt) begin
            sent_q <= 1'b1;
            ptr_q  <= next_q;
            idx_q  <= '0;
            st     <= ST_DREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_DREQ:  mem_addr = ptr_q + W'(idx_q) * STEP;
      ST_BREQ:  mem_addr = buf_q;
      ST_WBACK: mem_addr = ptr_q + STEP;
      default:  mem_addr = ptr_q;
    endcase
  end

  assign mem_req      = (st == ST_DREQ) || (st == ST_BREQ) || (st == ST_WBACK);
  assign mem_we       = (st == ST_WBACK);
  assign mem_wdata    = size_q | (W'(1) << EMPTY_BIT);
  assign dma_en       = dma_en_q;
  assign desc_base    = base_q;
  assign evt_sent     = sent_q;
  assign evt_underrun = und_q;

  tx_byte_unpack #(.W(W)) u_unpack (
    .clk(clk), .rst(rst), .ld(ld), .ld_word(mem_rdata), .ld_cnt(ld_cnt),
    .ld_last(ld_last), .out_valid(up_valid), .out_data(up_data),
    .out_last(up_last), .out_ready(up_ready), .busy(up_busy)
  );

  tx_stream_steer u_steer (
    .sel_lb(lb_sel_q), .in_valid(up_valid), .in_data(up_data), .in_last(up_last),
    .in_ready(up_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .lb_valid(lb_valid), .lb_data(lb_data), .lb_last(lb_last),
    .lb_ready(lb_ready)
  );
endmodule

// File: rtl/tx_desc_dma_chk.sv
module tx_desc_dma_chk #(
  parameter int W         = 32,
  parameter int EMPTY_BIT = 31
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_gnt,
  input logic         tx_valid,
  input logic [7:0]   tx_data,
  input logic         tx_last,
  input logic         tx_ready,
  input logic         lb_valid,
  input logic [7:0]   lb_data,
  input logic         lb_last,
  input logic         lb_ready,
  input logic         dma_en,
  input logic [W-1:0] desc_base,
  input logic         evt_sent,
  input logic         evt_underrun
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !tx_valid && !lb_valid && !dma_en)); // R1
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    desc_base[1:0] == 2'b00); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
  AST_LB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_data) && $stable(lb_last))); // R6
  AST_WB_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[EMPTY_BIT]); // R8
  AST_UNDERRUN_DISABLES: assert property (@(posedge clk) disable iff (rst)
    evt_underrun |-> (!dma_en && !evt_sent)); // R9
  AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && lb_valid)); // R10
endmodule

bind tx_desc_dma tx_desc_dma_chk #(.W(W), .EMPTY_BIT(EMPTY_BIT)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_last(tx_last), .tx_ready(tx_ready), .lb_valid(lb_valid), .lb_data(lb_data),
  .lb_last(lb_last), .lb_ready(lb_ready), .dma_en(dma_en), .desc_base(desc_base),
  .evt_sent(evt_sent), .evt_underrun(evt_underrun)
);

// File: tb/tx_desc_dma_test.sv
`timescale 1ns/1ps
module tx_desc_dma_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tx_en = 1'b0, cfg_loopback = 1'b0;
  logic dma_en_wr = 1'b0, dma_en_wdata = 1'b0, base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic dma_en;
  logic [31:0] desc_base;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_last, lb_valid, lb_last, evt_sent, evt_underrun;
  logic [7:0] tx_data, lb_data;
  logic tx_ready = 1'b0, lb_ready = 1'b0;

  always #5 clk = ~clk;

  tx_desc_dma uut (
    .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_loopback(cfg_loopback),
    .dma_en_wr(dma_en_wr), .dma_en_wdata(dma_en_wdata), .base_wr(base_wr),
    .base_wdata(base_wdata), .dma_en(dma_en), .desc_base(desc_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_last(lb_last), .lb_ready(lb_ready),
    .evt_sent(evt_sent), .evt_underrun(evt_underrun)
  );

  logic [31:0] mem [0:1023];
  int exp_addr[$];
  bit exp_we[$];
  int exp_wd[$];
  int exp_byte[$];
  bit exp_last[$];
  bit exp_lb[$];
  int nvec = 0, nerr = 0;
  int sent_cnt = 0, und_cnt = 0, req_cycles = 0, wr_cnt = 0, tx_cycles = 0;
  bit stall = 1'b0, bp = 1'b0, finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pat(int b, int i);
    return ((b >> 4) + i * 7 + 3) & 255;
  endfunction

  // Spec-level expectation for one descriptor (R4, R5, R7, R8, R10)
  task automatic put_desc(int d, int b, int sizew, int nxt, bit lb);
    int len, nw;
    mem[d >> 2] = b; mem[(d >> 2) + 1] = sizew; mem[(d >> 2) + 2] = nxt;
    for (int k = 0; k < 3; k++) begin
      exp_addr.push_back(d + 4 * k); exp_we.push_back(1'b0); exp_wd.push_back(0);
    end
    if (sizew[31]) return;
    len = sizew & 'h7FF;
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] w;
      for (int j = 0; j < 4; j++)
        w[8*j +: 8] = (4*k + j < len) ? 8'(pat(b, 4*k + j)) : 8'hEE;
      mem[(b >> 2) + k] = w;
      exp_addr.push_back(b + 4 * k); exp_we.push_back(1'b0); exp_wd.push_back(0);
    end
    for (int i = 0; i < len; i++) begin
      exp_byte.push_back(pat(b, i)); exp_last.push_back(i == len - 1); exp_lb.push_back(lb);
    end
    exp_addr.push_back(d + 4); exp_we.push_back(1'b1); exp_wd.push_back(sizew | 32'h8000_0000);
  endtask

  // Memory and sink models, driven away from the active edge
  initial begin
    int rd_cnt = 0, rd_a = 0, tick = 0;
    forever begin
      @(negedge clk);
      tick++;
      if (rd_cnt > 0) begin
        rd_cnt--;
        mem_rvalid = (rd_cnt == 0);
        if (rd_cnt == 0) mem_rdata = mem[(rd_a >> 2) & 1023];
      end else mem_rvalid = 1'b0;
      if (mem_req) req_cycles++;
      if (mem_req && (!stall || tick % 3 == 0)) begin
        mem_gnt = 1'b1;
        if (exp_addr.size() == 0) chk(0, "R4", "unexpected request", mem_addr, 0);
        else begin
          int ea, ew; bit ewe;
          ea = exp_addr.pop_front(); ewe = exp_we.pop_front(); ew = exp_wd.pop_front();
          chk(mem_addr == ea && mem_we == ewe, "R4", "request addr/we", {mem_we, mem_addr}, {ewe, ea});
          if (ewe) chk(mem_wdata == ew, "R8", "writeback data", mem_wdata, ew);
        end
        if (mem_we) begin
          wr_cnt++;
          mem[(mem_addr >> 2) & 1023] = mem_wdata;
        end else begin
          rd_cnt = 2; rd_a = mem_addr;
        end
      end else mem_gnt = 1'b0;
      // R6: back-pressure pattern on both sinks
      tx_ready = bp ? (tick % 2 == 1) : 1'b1;
      lb_ready = bp ? (tick % 3 != 0) : 1'b1;
      if (tx_valid) tx_cycles++;
      if ((tx_valid && tx_ready) || (lb_valid && lb_ready)) begin
        bit is_lb; logic [7:0] d; bit l;
        is_lb = lb_valid; d = is_lb ? lb_data : tx_data; l = is_lb ? lb_last : tx_last;
        if (exp_byte.size() == 0) chk(0, "R5", "unexpected byte", d, 0);
        else begin
          int eb; bit el, elb;
          eb = exp_byte.pop_front(); el = exp_last.pop_front(); elb = exp_lb.pop_front();
          chk(d == 8'(eb) && l == el, "R5", "byte/last", {l, d}, {el, 8'(eb)});
          chk(is_lb == elb, "R10", "sink port", is_lb, elb);
        end
      end
      if (evt_sent) sent_cnt++;
      if (evt_underrun) und_cnt++;
    end
  end

  task automatic pulse_en(bit v);
    @(negedge clk); dma_en_wr = 1'b1; dma_en_wdata = v;
    @(negedge clk); dma_en_wr = 1'b0;
  endtask

  task automatic set_base(int a);
    @(negedge clk); base_wr = 1'b1; base_wdata = a;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic wait_und(int target);
    int g = 0;
    while (und_cnt < target && g < 5000) begin @(negedge clk); g++; end
    chk(und_cnt >= target, "R9", "chain end reached", und_cnt, target);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s0, u0, w0, r0, t0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dma_en == 0 && desc_base == 0, "R1", "reset regs", {dma_en, desc_base}, 0);
    chk(!mem_req && !tx_valid && !lb_valid && !evt_sent && !evt_underrun, "R1", "reset outputs",
        {mem_req, tx_valid, lb_valid, evt_sent, evt_underrun}, 0);

    set_base('h103);
    chk(desc_base == 'h100, "R2", "base alignment", desc_base, 'h100);

    // R3: enable without transmit enable
    r0 = req_cycles;
    pulse_en(1'b1);
    repeat (20) @(negedge clk);
    chk(req_cycles == r0, "R3", "no request when tx disabled", req_cycles - r0, 0);
    chk(dma_en == 1, "R3", "enable bit stored", dma_en, 1);
    pulse_en(1'b0);

    // Main chain: 5 bytes (stray upper bits), zero length (R7), 8 bytes, then empty
    put_desc('h100, 'h400, 'h0000_F805, 'h110, 0);
    put_desc('h110, 'h500, 0, 'h120, 0);
    put_desc('h120, 'h600, 8, 'h130, 0);
    put_desc('h130, 0, 'h8000_0000, 0, 0);
    stall = 1'b1; bp = 1'b1; cfg_tx_en = 1'b1;
    s0 = sent_cnt; u0 = und_cnt;
    pulse_en(1'b1);
    repeat (6) @(negedge clk);
    pulse_en(1'b0); // R11: ignored during the walk
    wait_und(u0 + 1);
    chk(sent_cnt - s0 == 3, "R8", "sent events", sent_cnt - s0, 3);
    chk(und_cnt - u0 == 1, "R9", "underrun events", und_cnt - u0, 1);
    chk(dma_en == 0, "R9", "enable cleared", dma_en, 0);
    chk(exp_addr.size() == 0, "R11", "walk finished all requests", exp_addr.size(), 0);
    chk(exp_byte.size() == 0, "R5", "all bytes sent", exp_byte.size(), 0);
    chk(mem['h104 >> 2] == 32'h8000_F805, "R8", "size word marked", mem['h104 >> 2], 32'h8000_F805);
    chk(mem['h114 >> 2] == 32'h8000_0000, "R7", "zero-length written back", mem['h114 >> 2], 32'h8000_0000);

    // Loopback frame
    set_base('h200);
    put_desc('h200, 'h700, 3, 'h210, 1);
    put_desc('h210, 0, 'h8000_0000, 0, 1);
    cfg_loopback = 1'b1; stall = 1'b0;
    t0 = tx_cycles; u0 = und_cnt;
    pulse_en(1'b1);
    wait_und(u0 + 1);
    chk(tx_cycles == t0, "R10", "transmit port idle", tx_cycles - t0, 0);
    chk(exp_byte.size() == 0, "R10", "loopback bytes delivered", exp_byte.size(), 0);
    cfg_loopback = 1'b0;

    // Chain that starts empty
    set_base('h300);
    put_desc('h300, 0, 'h8000_0123, 0, 0);
    s0 = sent_cnt; u0 = und_cnt; w0 = wr_cnt;
    pulse_en(1'b1);
    wait_und(u0 + 1);
    chk(wr_cnt == w0 && sent_cnt == s0, "R9", "no write on empty", wr_cnt - w0, 0);
    chk(dma_en == 0, "R9", "enable cleared again", dma_en, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule